// File: doc/BRIEF.md
# Scanned RGB LED Matrix Driver

This block lights a 12-column by 10-row field of RGB LEDs through time multiplexing. At any moment exactly one column is enabled by a 4-bit binary column code. Three 10-bit row vectors, one each for red, green and blue, are active-low. They switch on the LEDs of the enabled column. The host side is active-high. Each pixel keeps a 3-bit on/off colour, which gives eight colours from black to white. The colour is loaded through a synchronous write port that takes a column, a row, a colour and a write strobe.

The block owns the scan timing. The column step rate is 1 kHz, which is 50,000 cycles of a 50 MHz clock. Each step begins with a short blanking gap: the column code is 15 and every row line is high. This prevents ghosting while the column changes. A mode input selects one of two modes. In colour mode each pixel's own 3-bit value drives its LED. In single-colour mode bit 0 of the pixel is an on/off flag, and a shared 3-bit colour input chooses which components light.

Top module: `led_matrix_scan`

## Requirements
- R1: Column codes 0 to 11 enable columns 0 to 11. Columns are shown in the order 0,1,…,11 and then wrap to 0. After its blanking gap, each column is displayed for HOLD−BLANK clock cycles.
- R2: Between two displayed columns there are exactly BLANK cycles in which the column code is 15 and all red, green and blue row lines are 1. Any code of 12 or more always comes with all row lines at 1.
- R3: While reset is high, and in the first cycle after it, the column code is 15 and all row lines are 1. Column 0 first appears BLANK+1 clock edges after reset is released.
- R4: In colour mode, row line n of the displayed column is the inverse of that pixel's colour bit. Bit 0 is red, bit 1 is green and bit 2 is blue.
- R5: In single-colour mode, a pixel whose stored bit 0 is 1 lights the components that are set in the shared colour input, with bit 0 red, bit 1 green and bit 2 blue. A pixel whose bit 0 is 0 stays dark. Changing the mode or the shared colour takes effect on the display within two cycles.
- R6: A write whose column is 12 or more, or whose row is 10 or more, changes no pixel.
- R7: Reset clears every pixel to black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | pixel write strobe |
| wr_col | input | 4 | column of the pixel written |
| wr_row | input | 4 | row of the pixel written |
| wr_rgb | input | 3 | colour written (bit0 red, bit1 green, bit2 blue) |
| mono_mode | input | 1 | 1 selects single-colour mode |
| mono_rgb | input | 3 | shared colour for single-colour mode |
| col_addr | output | 4 | binary column code, 15 = blank |
| red_n | output | 10 | red row lines, active-low |
| green_n | output | 10 | green row lines, active-low |
| blue_n | output | 10 | blue row lines, active-low |

## Verification
The hardest situation to reach from the ports is the exact handover between columns. A wrong blanking length, a skipped column or a wrong wrap from 11 back to 0 only shows up across whole frames. The bench shortens the hold parameter so that complete frames run quickly. It then follows the column code on every cycle, measures each display run and each blank gap, and checks the order of columns through the wrap. At the same time it compares the row lines of every displayed cycle against its own pixel model, in both modes.

// File: rtl/led_matrix_scan.sv
module led_matrix_scan #(
  parameter int COLS  = 12,
  parameter int ROWS  = 10,
  parameter int HOLD  = 50000,
  parameter int BLANK = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(COLS+1)-1:0]   wr_col,
  input  logic [$clog2(ROWS+1)-1:0]   wr_row,
  input  logic [2:0]                  wr_rgb,
  input  logic                        mono_mode,
  input  logic [2:0]                  mono_rgb,
  output logic [$clog2(COLS+1)-1:0]   col_addr,
  output logic [ROWS-1:0]             red_n,
  output logic [ROWS-1:0]             green_n,
  output logic [ROWS-1:0]             blue_n
);
  localparam int CW = $clog2(COLS+1);
  localparam int TW = $clog2(HOLD);
  localparam logic [CW-1:0] OFF = {CW{1'b1}};

  logic [2:0]    pix [COLS][ROWS];
  logic [TW-1:0] tick;
  logic [CW-1:0] col;
  logic [ROWS-1:0] lit_r, lit_g, lit_b;
  logic          blank;
  logic          wr_ok;

  assign blank = (int'(tick) < BLANK);
  assign wr_ok = wr_en && (int'(wr_col) < COLS) && (int'(wr_row) < ROWS);

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      logic [2:0] on;
      on = mono_mode ? ({3{pix[col][r][0]}} & mono_rgb) : pix[col][r];
      lit_r[r] = on[0];
      lit_g[r] = on[1];
      lit_b[r] = on[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick     <= '0;
      col      <= '0;
      col_addr <= OFF;
      red_n    <= '1;
      green_n  <= '1;
      blue_n   <= '1;
      for (int c = 0; c < COLS; c++)
        for (int r = 0; r < ROWS; r++)
          pix[c][r] <= 3'b000;
    end else begin
      if (wr_ok)
        pix[wr_col][wr_row] <= wr_rgb;
      if (int'(tick) == HOLD-1) begin
        tick <= '0;
        col  <= (int'(col) == COLS-1) ? '0 : col + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
      if (blank) begin
        col_addr <= OFF;
        red_n    <= '1;
        green_n  <= '1;
        blue_n   <= '1;
      end else begin
        col_addr <= col;
        red_n    <= ~lit_r;
        green_n  <= ~lit_g;
        blue_n   <= ~lit_b;
      end
    end
  end
endmodule

// File: rtl/led_matrix_scan_chk.sv
module led_matrix_scan_chk #(
  parameter int COLS = 12,
  parameter int ROWS = 10
) (
  input logic                      clk,
  input logic                      rst,
  input logic [$clog2(COLS+1)-1:0] col_addr,
  input logic [ROWS-1:0]           red_n,
  input logic [ROWS-1:0]           green_n,
  input logic [ROWS-1:0]           blue_n
);
  localparam int CW = $clog2(COLS+1);
  localparam logic [CW-1:0] OFF = {CW{1'b1}};

  logic [CW-1:0] last_col;
  logic [CW-1:0] next_col;

  always_ff @(posedge clk) begin
    if (rst) last_col <= CW'(COLS-1);
    else if (int'(col_addr) < COLS) last_col <= col_addr;
  end
  assign next_col = (int'(last_col) == COLS-1) ? '0 : last_col + 1'b1;

  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (int'(col_addr) < COLS) || (col_addr == OFF)); // R1

  AST_COL_ORDER: assert property (@(posedge clk) disable iff (rst)
    (col_addr != OFF && $past(col_addr) == OFF) |-> col_addr == next_col); // R1

  AST_BLANK_ROWS: assert property (@(posedge clk) disable iff (rst)
    (int'(col_addr) >= COLS) |-> (&red_n && &green_n && &blue_n)); // R2

  AST_GAP_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (int'(col_addr) < COLS && int'($past(col_addr)) < COLS) |-> col_addr == $past(col_addr)); // R2

  AST_RESET_BLANK: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (col_addr == OFF && &red_n && &green_n && &blue_n)); // R3
endmodule

bind led_matrix_scan led_matrix_scan_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .col_addr(col_addr),
  .red_n(red_n), .green_n(green_n), .blue_n(blue_n)
);

// File: tb/sim_led_matrix_scan.sv
`timescale 1ns/1ps
module sim_led_matrix_scan;
  localparam int COLS = 12, ROWS = 10, HOLD = 24, BLANK = 4;

  logic clk = 0, rst = 1, wr_en = 0, mono_mode = 0;
  logic [3:0] wr_col = 0, wr_row = 0, col_addr;
  logic [2:0] wr_rgb = 0, mono_rgb = 0;
  logic [ROWS-1:0] red_n, green_n, blue_n;
  logic [2:0] m [COLS][ROWS];
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  led_matrix_scan #(.COLS(COLS), .ROWS(ROWS), .HOLD(HOLD), .BLANK(BLANK)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_col(wr_col), .wr_row(wr_row),
    .wr_rgb(wr_rgb), .mono_mode(mono_mode), .mono_rgb(mono_rgb),
    .col_addr(col_addr), .red_n(red_n), .green_n(green_n), .blue_n(blue_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) m[c][r] = 3'b000;
  endtask

  task automatic do_reset(input string req);
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk({req, " blank in reset"}, {col_addr, red_n, green_n, blue_n}, {4'hF, {3*ROWS{1'b1}}});
    @(negedge clk); rst = 0;
    clear_model();
    for (int k = 1; k <= BLANK + 1; k++) begin
      @(negedge clk);
      if (k <= BLANK) chk({req, " blank after reset"}, col_addr, 4'hF);
      else            chk({req, " first column 0"}, col_addr, 4'h0);
    end
  endtask

  task automatic write_px(input int c, input int r, input logic [2:0] v);
    @(negedge clk);
    wr_en = 1; wr_col = 4'(c); wr_row = 4'(r); wr_rgb = v;
    @(negedge clk);
    wr_en = 0;
    if (c < COLS && r < ROWS) m[c][r] = v;
  endtask

  task automatic frame_check(input string req, input int frames);
    for (int i = 0; i < frames * COLS * HOLD; i++) begin
      @(negedge clk);
      if (col_addr < COLS) begin
        logic [ROWS-1:0] er, eg, eb;
        for (int r = 0; r < ROWS; r++) begin
          logic [2:0] on;
          on = mono_mode ? ({3{m[col_addr][r][0]}} & mono_rgb) : m[col_addr][r];
          er[r] = ~on[0]; eg[r] = ~on[1]; eb[r] = ~on[2];
        end
        chk(req, {red_n, green_n, blue_n}, {er, eg, eb});
      end else begin
        chk({req, " R2 blank rows"}, {red_n, green_n, blue_n}, {3*ROWS{1'b1}});
      end
    end
  endtask

  task automatic t_timing();
    logic [3:0] prev = col_addr;
    int run = 0, last_shown = -1, seen = 0;
    for (int i = 0; i < 3 * COLS * HOLD; i++) begin
      @(negedge clk);
      if (col_addr != prev) begin
        if (seen > 0) begin
          if (prev == 4'hF) chk("R2 blank length", run, BLANK);
          else              chk("R1 display length", run, HOLD - BLANK);
        end
        if (col_addr != 4'hF) begin
          if (last_shown >= 0) chk("R1 column order", col_addr, (last_shown + 1) % COLS);
          last_shown = col_addr;
        end
        seen++;
        run = 0;
      end
      run++;
      prev = col_addr;
    end
  endtask

  task automatic t_rgb();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++) write_px(c, r, 3'((c + 3 * r) % 8));
    repeat (2) @(negedge clk);
    frame_check("R4 colour mode", 1);
  endtask

  task automatic t_mono();
    mono_mode = 1; mono_rgb = 3'b101;
    repeat (2) @(negedge clk);
    frame_check("R5 mono red+blue", 1);
    mono_rgb = 3'b010;
    repeat (2) @(negedge clk);
    frame_check("R5 mono green", 1);
    mono_mode = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_ignore();
    write_px(12, 0, 3'b111);
    write_px(3, 10, 3'b111);
    write_px(15, 15, 3'b111);
    write_px(0, 12, 3'b111);
    repeat (2) @(negedge clk);
    frame_check("R6 out-of-range write ignored", 1);
  endtask

  task automatic t_clear();
    write_px(5, 5, 3'b111);
    do_reset("R3");
    frame_check("R7 pixels cleared by reset", 1);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_model();
    do_reset("R3");
    t_timing();
    t_rgb();
    t_mono();
    t_ignore();
    t_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule